// File: doc/BRIEF.md
# Indirect Register Window with Address Pointer

This block lets a host reach a large set of internal registers through a few I/O offsets. The host first writes a register index into a pointer register. It then reads or writes one of two data ports, and the access goes to the register that the stored pointer names. One data port serves the control/status bank and the other serves the bus-configuration bank. Both ports share the same pointer, so switching banks does not require a new pointer write.

Two I/O width modes are supported: 16-bit word mode and 32-bit doubleword mode. The control/status data port sits at offset 10h in both modes. The pointer and the bus-configuration data port move with the mode. The mode pin is captured once after reset and stays frozen until the next reset. An offset that belongs only to the other mode is not decoded. The register banks live outside this block, behind a simple index, strobe and data interface.

Top module: `regptr_window`

## Requirements
- R1: After reset the pointer is zero. A pointer read returns 0, and `reg_idx_o` is 0.
- R2: In word mode (mode captured as 0), a write at offset 12h stores `io_wdata_i[IDX_W-1:0]` into the pointer from the next cycle. A read at 12h returns the pointer, zero-extended.
- R3: In doubleword mode (mode captured as 1), the pointer is written and read at offset 14h, with the same width rules as R2.
- R4: An access at offset 10h goes to the control/status bank. A read raises `csr_rd_o` and returns `csr_rdata_i` on `io_rdata_o` in the same cycle. A write raises `csr_wr_o` with `reg_idx_o` equal to the pointer.
- R5: The bus-configuration data port is at offset 16h in word mode and 1Ch in doubleword mode. It uses `bcr_rd_o`, `bcr_wr_o` and `bcr_rdata_i` with the same pointer value as R4.
- R6: Data port accesses never change the pointer. Repeated accesses reach the same register until the pointer is rewritten.
- R7: In a given mode, the pointer and bus-configuration offsets of the other mode are not decoded. Accesses there raise no strobe, return 0 and leave the pointer unchanged.
- R8: The mode is taken from `mode_dw_i` on the first clock edge after the internal reset releases. Later changes of `mode_dw_i` have no effect until the next reset.
- R9: In word mode, `io_rdata_o[31:16]` and `reg_wdata_o[31:16]` are zero. In doubleword mode all 32 bits pass through.
- R10: With `io_sel_i` low, no strobe is raised and `io_rdata_o` is 0. At most one bank strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_dw_i | input | 1 | Width mode: 1 selects doubleword, 0 selects word; captured after reset |
| io_sel_i | input | 1 | I/O access valid this cycle |
| io_wr_i | input | 1 | 1 = write, 0 = read |
| io_off_i | input | 5 | I/O offset within the window |
| io_wdata_i | input | 32 | Write data from the host |
| io_rdata_o | output | 32 | Read data to the host, valid in the access cycle |
| reg_idx_o | output | 7 | Current pointer, used as the register index for both banks |
| reg_wdata_o | output | 32 | Write data to the banks, masked to the mode width |
| csr_rd_o | output | 1 | Control/status bank read strobe |
| csr_wr_o | output | 1 | Control/status bank write strobe |
| csr_rdata_i | input | 32 | Control/status bank read data |
| bcr_rd_o | output | 1 | Bus-configuration bank read strobe |
| bcr_wr_o | output | 1 | Bus-configuration bank write strobe |
| bcr_rdata_i | input | 32 | Bus-configuration bank read data |

## Verification
Some properties are checked on every cycle:
- at most one bank strobe is high, and no strobe is high without a select;
- the index stays put except after a pointer write, and takes the written value after one;
- the captured mode does not move once locked;
- word-mode read data has a clear upper half.

Other behaviour needs the bench's scenarios:
- that each bank port returns the register named by the pointer, across all 128 indices in both modes;
- that writes actually land in the right bank;
- that offsets of the other mode are inert;
- that toggling the mode pin after capture leaves the decode unchanged.

// File: rtl/regptr_pkg.sv
package regptr_pkg;
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_PTR  = 2'd1,
    ACC_CSR  = 2'd2,
    ACC_BCR  = 2'd3
  } acc_e;
endpackage

// File: rtl/regptr_rstsync.sv
module regptr_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_s_n = sync_q[STAGES-1];
endmodule

// File: rtl/regptr_decode.sv
module regptr_decode
  import regptr_pkg::*;
#(
  parameter int unsigned OFF_W     = 5,
  parameter int unsigned CSR_OFF   = 16,
  parameter int unsigned PTR_OFF_W = 18,
  parameter int unsigned PTR_OFF_D = 20,
  parameter int unsigned BCR_OFF_W = 22,
  parameter int unsigned BCR_OFF_D = 28
) (
  input  logic             sel_i,
  input  logic             locked_i,
  input  logic             mode_dw_i,
  input  logic [OFF_W-1:0] off_i,
  output acc_e             acc_o
);
  localparam logic [OFF_W-1:0] CSR_A  = OFF_W'(CSR_OFF);
  localparam logic [OFF_W-1:0] PTR_WA = OFF_W'(PTR_OFF_W);
  localparam logic [OFF_W-1:0] PTR_DA = OFF_W'(PTR_OFF_D);
  localparam logic [OFF_W-1:0] BCR_WA = OFF_W'(BCR_OFF_W);
  localparam logic [OFF_W-1:0] BCR_DA = OFF_W'(BCR_OFF_D);

  logic [OFF_W-1:0] ptr_a;
  logic [OFF_W-1:0] bcr_a;

  always_comb begin
    ptr_a = mode_dw_i ? PTR_DA : PTR_WA;
    bcr_a = mode_dw_i ? BCR_DA : BCR_WA;
    acc_o = ACC_NONE;
    if (sel_i && locked_i) begin
      if (off_i == CSR_A)      acc_o = ACC_CSR;
      else if (off_i == ptr_a) acc_o = ACC_PTR;
      else if (off_i == bcr_a) acc_o = ACC_BCR;
    end
  end
endmodule

// File: rtl/regptr_ptr.sv
module regptr_ptr #(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             ptr_we_i,
  input  logic [IDX_W-1:0] ptr_wdata_i,
  output logic [IDX_W-1:0] ptr_o,
  output logic             mode_o,
  output logic             locked_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic             mode_q, mode_d;
  logic             locked_q, locked_d;

  always_comb begin
    ptr_d    = ptr_q;
    mode_d   = mode_q;
    locked_d = 1'b1;
    if (ptr_we_i) ptr_d  = ptr_wdata_i;
    if (!locked_q) mode_d = mode_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q    <= '0;
      mode_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      ptr_q    <= ptr_d;
      mode_q   <= mode_d;
      locked_q <= locked_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign mode_o   = mode_q;
  assign locked_o = locked_q;
endmodule

// File: rtl/regptr_window.sv
module regptr_window
  import regptr_pkg::*;
#(
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned OFF_W     = 5,
  parameter int unsigned CSR_OFF   = 16,
  parameter int unsigned PTR_OFF_W = 18,
  parameter int unsigned PTR_OFF_D = 20,
  parameter int unsigned BCR_OFF_W = 22,
  parameter int unsigned BCR_OFF_D = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_dw_i,
  input  logic              io_sel_i,
  input  logic              io_wr_i,
  input  logic [OFF_W-1:0]  io_off_i,
  input  logic [DATA_W-1:0] io_wdata_i,
  output logic [DATA_W-1:0] io_rdata_o,
  output logic [IDX_W-1:0]  reg_idx_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              csr_rd_o,
  output logic              csr_wr_o,
  input  logic [DATA_W-1:0] csr_rdata_i,
  output logic              bcr_rd_o,
  output logic              bcr_wr_o,
  input  logic [DATA_W-1:0] bcr_rdata_i
);
  localparam logic [DATA_W-1:0] WORD_MASK = {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};

  logic             rst_s_n;
  logic             mode_q;
  logic             locked_q;
  logic [IDX_W-1:0] ptr_q;
  acc_e             acc;
  logic             ptr_we;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] rsel;

  regptr_rstsync #(.STAGES(2)) i_rstsync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  regptr_decode #(
    .OFF_W(OFF_W), .CSR_OFF(CSR_OFF),
    .PTR_OFF_W(PTR_OFF_W), .PTR_OFF_D(PTR_OFF_D),
    .BCR_OFF_W(BCR_OFF_W), .BCR_OFF_D(BCR_OFF_D)
  ) i_decode (
    .sel_i     (io_sel_i),
    .locked_i  (locked_q),
    .mode_dw_i (mode_q),
    .off_i     (io_off_i),
    .acc_o     (acc)
  );

  assign ptr_we = (acc == ACC_PTR) && io_wr_i;

  regptr_ptr #(.IDX_W(IDX_W)) i_ptr (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .mode_i      (mode_dw_i),
    .ptr_we_i    (ptr_we),
    .ptr_wdata_i (io_wdata_i[IDX_W-1:0]),
    .ptr_o       (ptr_q),
    .mode_o      (mode_q),
    .locked_o    (locked_q)
  );

  always_comb begin
    lane_mask = mode_q ? {DATA_W{1'b1}} : WORD_MASK;
    rsel      = '0;
    if (!io_wr_i) begin
      unique case (acc)
        ACC_PTR:  rsel = DATA_W'(ptr_q);
        ACC_CSR:  rsel = csr_rdata_i;
        ACC_BCR:  rsel = bcr_rdata_i;
        default:  rsel = '0;
      endcase
    end
  end

  assign io_rdata_o  = rsel & lane_mask;
  assign reg_wdata_o = io_wdata_i & lane_mask;
  assign reg_idx_o   = ptr_q;
  assign csr_rd_o    = (acc == ACC_CSR) && !io_wr_i;
  assign csr_wr_o    = (acc == ACC_CSR) &&  io_wr_i;
  assign bcr_rd_o    = (acc == ACC_BCR) && !io_wr_i;
  assign bcr_wr_o    = (acc == ACC_BCR) &&  io_wr_i;
endmodule

// File: rtl/regptr_chk.sv
module regptr_chk #(
  parameter int unsigned IDX_W     = 7,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WORD_W    = 16,
  parameter int unsigned OFF_W     = 5,
  parameter int unsigned PTR_OFF_W = 18,
  parameter int unsigned PTR_OFF_D = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_q,
  input logic              locked_q,
  input logic              io_sel_i,
  input logic              io_wr_i,
  input logic [OFF_W-1:0]  io_off_i,
  input logic [DATA_W-1:0] io_wdata_i,
  input logic [DATA_W-1:0] io_rdata_o,
  input logic [IDX_W-1:0]  reg_idx_o,
  input logic              csr_rd_o,
  input logic              csr_wr_o,
  input logic              bcr_rd_o,
  input logic              bcr_wr_o
);
  logic ptr_hit;
  assign ptr_hit = io_sel_i && io_wr_i && locked_q &&
                   (io_off_i == (mode_q ? OFF_W'(PTR_OFF_D) : OFF_W'(PTR_OFF_W)));

  // R10
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({csr_rd_o, csr_wr_o, bcr_rd_o, bcr_wr_o}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !io_sel_i |-> (!csr_rd_o && !csr_wr_o && !bcr_rd_o && !bcr_wr_o && io_rdata_o == '0));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ptr_hit |=> $stable(reg_idx_o));

  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_hit |=> reg_idx_o == $past(io_wdata_i[IDX_W-1:0]));

  // R8
  mode_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_q));

  // R9
  word_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked_q && !mode_q) |-> io_rdata_o[DATA_W-1:WORD_W] == '0);
endmodule

bind regptr_window regptr_chk #(
  .IDX_W(IDX_W), .DATA_W(DATA_W), .WORD_W(WORD_W), .OFF_W(OFF_W),
  .PTR_OFF_W(PTR_OFF_W), .PTR_OFF_D(PTR_OFF_D)
) i_chk (
  .clk        (clk),
  .rst_n      (rst_s_n),
  .mode_q     (mode_q),
  .locked_q   (locked_q),
  .io_sel_i   (io_sel_i),
  .io_wr_i    (io_wr_i),
  .io_off_i   (io_off_i),
  .io_wdata_i (io_wdata_i),
  .io_rdata_o (io_rdata_o),
  .reg_idx_o  (reg_idx_o),
  .csr_rd_o   (csr_rd_o),
  .csr_wr_o   (csr_wr_o),
  .bcr_rd_o   (bcr_rd_o),
  .bcr_wr_o   (bcr_wr_o)
);

// File: tb/test_regptr_window.sv
`timescale 1ns/1ps
module test_regptr_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode_dw;
  logic        io_sel, io_wr;
  logic [4:0]  io_off;
  logic [31:0] io_wdata, io_rdata;
  logic [6:0]  reg_idx;
  logic [31:0] reg_wdata;
  logic        csr_rd, csr_wr, bcr_rd, bcr_wr;
  logic [31:0] csr_rdata, bcr_rdata;
  logic [31:0] csr_mem [128];
  logic [31:0] bcr_mem [128];

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  regptr_window i_regptr_window (
    .clk(clk), .rst_n(rst_n), .mode_dw_i(mode_dw),
    .io_sel_i(io_sel), .io_wr_i(io_wr), .io_off_i(io_off),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .reg_idx_o(reg_idx), .reg_wdata_o(reg_wdata),
    .csr_rd_o(csr_rd), .csr_wr_o(csr_wr), .csr_rdata_i(csr_rdata),
    .bcr_rd_o(bcr_rd), .bcr_wr_o(bcr_wr), .bcr_rdata_i(bcr_rdata)
  );

  assign csr_rdata = csr_mem[reg_idx];
  assign bcr_rdata = bcr_mem[reg_idx];

  always @(posedge clk) begin
    if (csr_wr) csr_mem[reg_idx] <= reg_wdata;
    if (bcr_wr) bcr_mem[reg_idx] <= reg_wdata;
  end

  function automatic logic [31:0] csr_init(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0203;
  endfunction
  function automatic logic [31:0] bcr_init(int i);
    return 32'hC300_0000 ^ (32'(i) * 32'h0002_0107);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [4:0] off, input logic [31:0] d,
                     output logic [31:0] rd, output logic [3:0] st);
    @(negedge clk);
    io_sel = 1'b1; io_wr = wr; io_off = off; io_wdata = d;
    #2;
    rd = io_rdata;
    st = {csr_rd, csr_wr, bcr_rd, bcr_wr};
    @(posedge clk);
    #1 io_sel = 1'b0; io_wr = 1'b0;
  endtask

  task automatic run_mode(bit dw);
    logic [31:0] rd, mask;
    logic [3:0]  st;
    logic [4:0]  p_off, b_off, xp_off, xb_off;
    p_off  = dw ? 5'h14 : 5'h12;
    b_off  = dw ? 5'h1C : 5'h16;
    xp_off = dw ? 5'h12 : 5'h14;
    xb_off = dw ? 5'h16 : 5'h1C;
    mask   = dw ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    for (int i = 0; i < 128; i++) begin
      csr_mem[i] = csr_init(i);
      bcr_mem[i] = bcr_init(i);
    end
    mode_dw = dw;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(posedge clk);

    // R1 reset state
    chk("R1 idx", 32'(reg_idx), 32'h0);
    acc(0, p_off, 0, rd, st);
    chk("R1 ptr read", rd, 32'h0);

    // R2/R3/R4/R5/R9 index sweep
    for (int i = 0; i < 128; i++) begin
      acc(1, p_off, (32'h0002_4680 << 7) | 32'(i), rd, st);
      acc(0, p_off, 0, rd, st);
      chk(dw ? "R3 ptr readback" : "R2 ptr readback", rd, 32'(i));
      acc(0, 5'h10, 0, rd, st);
      chk("R4 csr read", rd, csr_init(i) & mask);
      chk("R4 csr rd strobe", 32'(st), 32'b1000);
      acc(0, b_off, 0, rd, st);
      chk("R5 bcr read", rd, bcr_init(i) & mask);
      chk("R5 bcr rd strobe", 32'(st), 32'b0010);
    end

    // R4/R5/R9 writes
    for (int i = 0; i < 128; i += 9) begin
      acc(1, p_off, 32'(i), rd, st);
      acc(1, 5'h10, 32'hDEAD_0000 + 32'(i), rd, st);
      chk("R4 csr wr strobe", 32'(st), 32'b0100);
      acc(0, 5'h10, 0, rd, st);
      chk("R9 csr write data", rd, (32'hDEAD_0000 + 32'(i)) & mask);
      acc(1, b_off, 32'hBEEF_0000 ^ 32'(i * 5), rd, st);
      chk("R5 bcr wr strobe", 32'(st), 32'b0001);
      acc(0, b_off, 0, rd, st);
      chk("R5 bcr write data", rd, (32'hBEEF_0000 ^ 32'(i * 5)) & mask);
      chk("R4 csr untouched by bcr write", csr_mem[i], (32'hDEAD_0000 + 32'(i)) & mask);
    end

    // R6 persistence
    acc(1, p_off, 32'd7, rd, st);
    for (int k = 0; k < 3; k++) begin
      acc(0, 5'h10, 0, rd, st);
      chk("R6 repeated read", rd, csr_init(7) & mask);
    end
    acc(1, 5'h10, 32'h0BAD_CAFE, rd, st);
    acc(1, b_off, 32'h1234_5678, rd, st);
    acc(0, 5'h10, 0, rd, st);
    chk("R6 read after write", rd, 32'h0BAD_CAFE & mask);
    acc(0, p_off, 0, rd, st);
    chk("R6 ptr kept", rd, 32'd7);

    // R7 offsets of the other mode
    acc(1, xp_off, 32'd3, rd, st);
    chk("R7 no strobe ptr", 32'(st), 32'b0);
    acc(0, xp_off, 0, rd, st);
    chk("R7 read zero ptr", rd, 32'h0);
    acc(0, xb_off, 0, rd, st);
    chk("R7 read zero bcr", rd, 32'h0);
    chk("R7 no strobe bcr", 32'(st), 32'b0);
    acc(1, xb_off, 32'hFFFF_FFFF, rd, st);
    chk("R7 bcr mem untouched", bcr_mem[7], 32'h1234_5678 & mask);
    acc(0, p_off, 0, rd, st);
    chk("R7 ptr unchanged", rd, 32'd7);

    // R10 no select
    @(negedge clk);
    io_sel = 1'b0; io_wr = 1'b1; io_off = 5'h10; io_wdata = 32'h5555_5555;
    #2;
    chk("R10 strobes idle", 32'({csr_rd, csr_wr, bcr_rd, bcr_wr}), 32'b0);
    chk("R10 rdata idle", io_rdata, 32'h0);
    @(posedge clk);
    #1 io_wr = 1'b0;
    chk("R10 mem untouched", csr_mem[7], 32'h0BAD_CAFE & mask);

    // R8 mode frozen
    mode_dw = ~dw;
    repeat (2) @(posedge clk);
    acc(1, p_off, 32'd11, rd, st);
    acc(0, p_off, 0, rd, st);
    chk("R8 mode frozen ptr", rd, 32'd11);
    acc(0, 5'h10, 0, rd, st);
    chk("R8 mode frozen width", rd, csr_init(11) & mask);
    mode_dw = dw;
  endtask

  initial begin
    rst_n = 1'b0; mode_dw = 1'b0;
    io_sel = 1'b0; io_wr = 1'b0; io_off = '0; io_wdata = '0;
    run_mode(1'b0);
    run_mode(1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule